// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an up-counting timer that restarts when its count equals a programmable period value, instead of when it overflows. A free-running divider derives a tick from the system clock, one tick every four clocks by default. That tick then passes through a prescaler with three ratios before it advances the counter. Each time the counter wraps, the block emits a single-clock match pulse. Neighbouring logic, such as a PWM generator or a serial shifter, can use this pulse directly as its time base.

A separate postscaler counts match pulses. After a programmable number of them, from one to sixteen, it sets a sticky flag. The flag drives an interrupt request only while the interrupt enable is set. Software reaches the counter, the period, the control word and the flag/enable pair through a small register port. Register writes take effect on the next clock. Reads return data one clock after the address is presented.

Top module: `period_timer`

## Requirements
- R1: After reset, the register port reads count (address 0) = 0x00, period (address 1) = 0xFF, control (address 2) = 0x00 and status (address 3) = 0x00.
- R2: While the run bit (control bit 2) is 0, the count does not change unless software writes it.
- R3: While running, consecutive match pulses are exactly TICK_DIV × prescale ratio × (period + 1) clocks apart. Each pulse is one clock wide, and the count reads 0 at the moment of the pulse.
- R4: Control bits 1:0 select the prescale ratio: 00 gives 1:1, 01 gives 1:4, and 10 or 11 gives 1:16.
- R5: Control bits 6:3 hold a value N. After the postscaler is cleared, the status flag (status bit 0) sets on match pulse number N+1.
- R6: The status flag stays set until software writes 0 to status bit 0. A flag set by hardware in the same clock as a software clear wins.
- R7: The irq output equals the status flag AND the interrupt enable (status bit 1).
- R8: A write to address 0 loads the count. Any write to address 0 or to address 2 clears both the prescale count and the postscale count.
- R9: The match pulse appears on every wrap, whatever the postscale setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 status |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data, valid one clock after the address |
| match_out | output | 1 | One-clock pulse on each period match, before the postscaler |
| irq | output | 1 | Interrupt request: flag gated by enable |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a divide-by-four tick and a 4-bit postscaler. With these settings, the longest period (0xFF at 1:1) and the largest postscale (1:16) both fit well within the cycle budget. Every prescale encoding, including both codes that select 1:16, is exercised. Each row of the table measures the gap between pulses and counts the match pulses up to the flag, so the period arithmetic and the postscaler are checked together at a range of corner values.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'b00,
    PRE_DIV4  = 2'b01,
    PRE_DIV16 = 2'b10,
    PRE_DIV16_ALT = 2'b11
  } prescale_e;

  // Terminal value of the 4-bit prescale count for each encoding.
  function automatic logic [3:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = 4'd0;
      2'b01:   pre_limit = 4'd3;
      default: pre_limit = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import timer_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] pre_sel,
  output logic       inc
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [3:0]       pre_q;
  logic             tick;

  assign tick = run && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
      pre_q <= '0;
      inc   <= 1'b0;
    end else begin
      inc <= 1'b0;
      if (run) begin
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end
      if (tick) begin
        if (pre_q >= pre_limit(pre_sel)) begin
          pre_q <= '0;
          inc   <= 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  // An advance pulse never lasts two clocks when the divider is above one.
  generate
    if (TICK_DIV > 1) begin : g_chk
      AST_INC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        inc |=> !inc); // R3
    end
  endgenerate
endmodule

// File: rtl/period_core.sv
module period_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             run,
  input  logic             cnt_we,
  input  logic             per_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period,
  output logic             match
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      period <= '1;
      match  <= 1'b0;
    end else begin
      match <= 1'b0;
      if (cnt_we) begin
        cnt <= wdata;
      end else if (inc) begin
        if (cnt == period) begin
          cnt   <= '0;
          match <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (per_we) period <= wdata;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    match |-> (cnt == '0)); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we && !inc) |=> $stable(cnt)); // R2
endmodule

// File: rtl/match_postscaler.sv
module match_postscaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            match,
  input  logic            clr,
  input  logic [PS_W-1:0] ratio,
  input  logic            stat_we,
  input  logic [1:0]      stat_wdata,
  output logic            flag,
  output logic            ie,
  output logic            irq
);
  logic [PS_W-1:0] post_q;
  logic            hw_set;
  logic            flag_d;
  logic            ie_d;

  assign hw_set = match && !clr && (post_q == ratio);

  always_comb begin
    flag_d = flag;
    ie_d   = ie;
    if (stat_we) begin
      flag_d = stat_wdata[0];
      ie_d   = stat_wdata[1];
    end
    if (hw_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q <= '0;
      flag   <= 1'b0;
      ie     <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (clr) begin
        post_q <= '0;
      end else if (match) begin
        post_q <= (post_q == ratio) ? '0 : post_q + 1'b1;
      end
      flag <= flag_d;
      ie   <= ie_d;
      irq  <= flag_d && ie_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_we) |=> flag); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hw_set && stat_we && !stat_wdata[0]) |=> flag); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie && flag)); // R7
endmodule

// File: rtl/period_timer.sv
module period_timer
  import timer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 4,
  parameter int PS_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             match_out,
  output logic             irq
);
  localparam int CTRL_W = PS_W + 3;

  logic [CTRL_W-1:0] ctrl_q;
  logic              run;
  logic [1:0]        pre_sel;
  logic [PS_W-1:0]   post_sel;
  logic              wr_cnt, wr_per, wr_ctrl, wr_stat;
  logic              clr_scalers;
  logic              inc;
  logic [CNT_W-1:0]  cnt, period;
  logic              flag, ie;
  logic [CNT_W-1:0]  rd_d;

  assign run      = ctrl_q[2];
  assign pre_sel  = ctrl_q[1:0];
  assign post_sel = ctrl_q[CTRL_W-1:3];

  assign wr_cnt  = bus_we && (bus_addr == ADDR_COUNT);
  assign wr_per  = bus_we && (bus_addr == ADDR_PERIOD);
  assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_we && (bus_addr == ADDR_STATUS);
  assign clr_scalers = wr_cnt || wr_ctrl;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(clr_scalers),
    .pre_sel(pre_sel), .inc(inc)
  );

  period_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .inc(inc), .run(run), .cnt_we(wr_cnt),
    .per_we(wr_per), .wdata(bus_wdata), .cnt(cnt), .period(period),
    .match(match_out)
  );

  match_postscaler #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst(rst), .match(match_out), .clr(clr_scalers),
    .ratio(post_sel), .stat_we(wr_stat), .stat_wdata(bus_wdata[1:0]),
    .flag(flag), .ie(ie), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      ADDR_COUNT:  rd_d = cnt;
      ADDR_PERIOD: rd_d = period;
      ADDR_CTRL:   rd_d = CNT_W'(ctrl_q);
      default:     rd_d = CNT_W'({ie, flag});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run)) |-> !match_out); // R2
endmodule

// File: tb/test_period_timer.sv
module test_period_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       match_out, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  period_timer i_period_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_out(match_out), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // period[13:6], prescale[5:4], postscale[3:0]
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {8'd0,   2'd0, 4'd0},
    {8'd5,   2'd1, 4'd0},
    {8'd3,   2'd2, 4'd2},
    {8'd10,  2'd3, 4'd1},
    {8'd255, 2'd0, 4'd3},
    {8'd1,   2'd1, 4'd15}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_match(output int n);
    n = 0;
    @(negedge clk);
    while (!match_out && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int ratio(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
  endfunction

  initial begin
    int v, n, gap, width;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(2'd0, v); check("R1 count", v, 0);
    rd(2'd1, v); check("R1 period", v, 255);
    rd(2'd2, v); check("R1 control", v, 0);
    rd(2'd3, v); check("R1 status", v, 0);
    check("R1 irq", int'(irq), 0);

    // R2: stopped timer holds count
    wr(2'd0, 8'h37);
    rd(2'd0, v); check("R8 count load", v, 8'h37);
    repeat (60) @(negedge clk);
    rd(2'd0, v); check("R2 hold while stopped", v, 8'h37);

    // Table walk: R3, R4, R5, R9
    for (int i = 0; i < NV; i++) begin
      logic [7:0] p;
      logic [1:0] ps;
      logic [3:0] po;
      p = VEC[i][13:6]; ps = VEC[i][5:4]; po = VEC[i][3:0];
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
      wr(2'd1, p);
      wr(2'd0, 8'h00);
      wr(2'd2, {1'b0, po, 1'b1, ps});
      // R5: count pulses until the flag sets
      n = 0;
      for (int c = 0; c < 60000; c++) begin
        @(negedge clk);
        if (match_out) n++;
        if (i_period_timer.irq === 1'bx) break;
        rd_flag_peek(v);
        if (v != 0) break;
      end
      check($sformatf("R5 row %0d pulses to flag", i), n, int'(po) + 1);
      // R3/R4/R9: gap between consecutive pulses, pulse width
      wait_match(n);
      @(negedge clk);
      width = match_out ? 2 : 1;
      gap = 1;
      while (!match_out && gap < 20000) begin
        @(negedge clk);
        gap++;
      end
      check($sformatf("R3 R4 R9 row %0d gap", i), gap, 4 * ratio(ps) * (int'(p) + 1));
      check($sformatf("R3 row %0d width", i), width, 1);
    end

    // R3: count reads zero right after a wrap (period 200, 1:16)
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd200);
    wr(2'd0, 8'd0);
    wr(2'd2, 8'b0_0000_1_10);
    wait_match(n);
    bus_addr = 2'd0;
    @(negedge clk);
    check("R3 count zero at wrap", int'(bus_rdata), 0);

    // R8: count write clears the postscaler (ratio 1:2)
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd20);
    wr(2'd0, 8'd0);
    wr(2'd2, 8'b0_0001_1_00);
    wait_match(n);
    wr(2'd0, 8'd0);
    wait_match(n);
    repeat (2) @(negedge clk);
    rd(2'd3, v); check("R8 postscale cleared by count write", v & 1, 0);
    wait_match(n);
    repeat (2) @(negedge clk);
    rd(2'd3, v); check("R8 flag after two fresh matches", v & 1, 1);

    // R6 / R7 with the timer stopped
    wr(2'd2, 8'h00);
    repeat (50) @(negedge clk);
    rd(2'd3, v); check("R6 flag sticky", v & 1, 1);
    check("R7 irq low with enable off", int'(irq), 0);
    wr(2'd3, 8'h03);
    @(negedge clk);
    check("R7 irq with flag and enable", int'(irq), 1);
    wr(2'd3, 8'h02);
    @(negedge clk);
    check("R7 irq drops with flag", int'(irq), 0);
    rd(2'd3, v); check("R6 flag cleared by write", v, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Non-intrusive flag observation: irq with enable off is never used here;
  // the flag is taken through the status register on the port.
  task automatic rd_flag_peek(output int f);
    bus_addr = 2'd3;
    @(negedge clk);
    f = int'(bus_rdata[0]);
    if (match_out) f = f;
  endtask
endmodule